// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status word of a small processor core: five arithmetic flags (half-carry, overflow, negative, zero, carry), a derived sign flag, a one-bit transfer store used by bit-copy instructions, and the global interrupt enable. The core's decoder drives it through plain strobes. The ALU presents its flags with a per-flag write mask, so an instruction changes only the flags it affects. A bit-store strobe copies one selected bit of a register operand into the transfer bit. The bit-load path returns the operand with the transfer bit placed at the selected index. Interrupt acceptance and return-from-interrupt strobes clear and set the enable.

Software reads and writes the whole word at one I/O address. The sign flag is never stored. It is always formed from the negative and overflow flags, so a value written into that bit position has no effect. The block also gates the per-source interrupt requests with the global enable. It does not save or restore the word on interrupt entry or return. That is left to software.

Top module: `psw_status_reg`

## Requirements
- R1: After reset every bit of the status word reads 0, and no interrupt request is forwarded.
- R2: The status word bit layout is bit7 I (interrupt enable), bit6 T (transfer bit), bit5 H, bit4 S, bit3 V, bit2 N, bit1 Z, bit0 C. An I/O write at address 0x3F loads every stored bit on the next clock. A write at any other address changes nothing. `io_rdata` shows the word while `io_addr` is 0x3F and 0 otherwise.
- R3: S always equals N xor V. This holds after ALU updates and after I/O writes, and the S value written over I/O is ignored.
- R4: An ALU update loads only the flags whose mask bit is set. The mask and flag vectors are ordered bit4 H, bit3 V, bit2 N, bit1 Z, bit0 C. Flags whose mask bit is clear keep their value.
- R5: When an I/O write and an ALU update fall in the same cycle, the ALU value wins on the masked flags and the written value applies to all other stored bits.
- R6: Request k is forwarded only when I is 1 and enable k is 1. With I at 0, no request is forwarded, whatever the enables hold.
- R7: Interrupt acceptance clears I on the next clock and overrides both a return strobe and an I/O write to I. A return strobe sets I and overrides an I/O write to I.
- R8: A bit-store copies bit `bit_idx` (0 to 7) of `bit_opnd` into T on the next clock, overriding an I/O write to T in the same cycle.
- R9: `bit_load_data` equals `bit_opnd` with bit `bit_idx` replaced by the current T, combinationally.
- R10: Interrupt acceptance and return change only I. All other bits of the word are left as they were, with no automatic save or restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 6 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (status word when addressed, else 0) |
| alu_mask | input | 5 | Per-flag update mask {H,V,N,Z,C} |
| alu_flags | input | 5 | New flag values {H,V,N,Z,C} |
| bit_idx | input | 3 | Selected bit for store/load |
| bit_opnd | input | 8 | Register operand |
| bit_store | input | 1 | Copy selected operand bit into T |
| bit_load_data | output | 8 | Operand with selected bit replaced by T |
| irq_accept | input | 1 | Interrupt accepted; clears I |
| irq_return | input | 1 | Return from interrupt; sets I |
| irq_req | input | 4 | Per-source interrupt requests |
| irq_en | input | 4 | Per-source enables |
| irq_fwd | output | 4 | Gated requests |
| status | output | 8 | Current status word |

## Verification
The bench writes all 256 byte values over I/O and checks that the S position always reads N xor V. A design that stored the written S bit would fail here on half of the values. Random masked ALU updates are run against an arithmetic model and catch a mask decoded in the wrong order or flags that leak past a clear mask bit. Same-cycle collisions of I/O write with the ALU, with bit-store, with acceptance and with return are each driven on purpose, since a swapped priority only shows up in those cycles. The bench sweeps every request and enable combination with I at both values, and runs a store-then-load round trip on every bit index. A wrong index decode or a missing global gate fails these sweeps.

// File: rtl/psw_pkg.sv
package psw_pkg;
   // Status word, MSB first
   typedef struct packed {
      logic i;
      logic t;
      logic h;
      logic s;
      logic v;
      logic n;
      logic z;
      logic c;
   } psw_t;

   localparam int unsigned PSW_W   = 8;
   localparam int unsigned ARITH_W = 5;  // {H,V,N,Z,C}
   localparam int unsigned AR_H = 4;
   localparam int unsigned AR_V = 3;
   localparam int unsigned AR_N = 2;
   localparam int unsigned AR_Z = 1;
   localparam int unsigned AR_C = 0;

   function automatic logic [ARITH_W-1:0] arith_of(psw_t w);
      return {w.h, w.v, w.n, w.z, w.c};
   endfunction
endpackage

// File: rtl/psw_bit_xfer.sv
module psw_bit_xfer #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic [DATA_W-1:0] opnd,
   input  logic [IDX_W-1:0]  idx,
   input  logic              t_in,
   output logic              sel_bit,
   output logic [DATA_W-1:0] load_data
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("psw_bit_xfer: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] hit;

   genvar k;
   generate
      for (k = 0; k < DATA_W; k++) begin : g_bit
         assign hit[k]       = (idx == IDX_W'(k));
         assign load_data[k] = hit[k] ? t_in : opnd[k];
      end
   endgenerate

   assign sel_bit = |(opnd & hit);
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
   parameter int unsigned NUM_IRQ = 4,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gie,
   input  logic [NUM_IRQ-1:0] req,
   input  logic [NUM_IRQ-1:0] en,
   output logic [NUM_IRQ-1:0] fwd
);
   generate
      if (NUM_IRQ < 1 || NUM_IRQ > 64) begin : g_bad_n
         $error("psw_irq_gate: NUM_IRQ out of range 1..64");
      end
   endgenerate

   logic [NUM_IRQ-1:0] gated;
   assign gated = req & en & {NUM_IRQ{gie}};

   generate
      if (REG_OUT) begin : g_reg
         logic [NUM_IRQ-1:0] fwd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fwd_q <= '0;
            else        fwd_q <= gated;
         end
         assign fwd = fwd_q;
      end else begin : g_comb
         assign fwd = gated;

         // R6
         gate_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|fwd) |-> gie);
      end
   endgenerate
endmodule

// File: rtl/psw_flag_store.sv
module psw_flag_store
   import psw_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_we,
   input  psw_t               io_word,
   input  logic [ARITH_W-1:0] alu_mask,
   input  logic [ARITH_W-1:0] alu_flags,
   input  logic               t_we,
   input  logic               t_val,
   input  logic               irq_accept,
   input  logic               irq_return,
   output psw_t               word
);
   logic               i_q, t_q;
   logic [ARITH_W-1:0] ar_q;
   logic               i_d, t_d;
   logic [ARITH_W-1:0] ar_d;
   logic [ARITH_W-1:0] io_ar;

   assign io_ar = arith_of(io_word);

   // Arithmetic flags: ALU mask beats I/O write, per flag
   genvar k;
   generate
      for (k = 0; k < ARITH_W; k++) begin : g_ar
         always_comb begin
            if (alu_mask[k])  ar_d[k] = alu_flags[k];
            else if (io_we)   ar_d[k] = io_ar[k];
            else              ar_d[k] = ar_q[k];
         end
      end
   endgenerate

   // Transfer bit: bit-store beats I/O write
   always_comb begin
      if (t_we)       t_d = t_val;
      else if (io_we) t_d = io_word.t;
      else            t_d = t_q;
   end

   // Enable: accept > return > I/O write
   always_comb begin
      if (irq_accept)      i_d = 1'b0;
      else if (irq_return) i_d = 1'b1;
      else if (io_we)      i_d = io_word.i;
      else                 i_d = i_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_q  <= 1'b0;
         t_q  <= 1'b0;
         ar_q <= '0;
      end else begin
         i_q  <= i_d;
         t_q  <= t_d;
         ar_q <= ar_d;
      end
   end

   always_comb begin
      word   = '0;
      word.i = i_q;
      word.t = t_q;
      word.h = ar_q[AR_H];
      word.v = ar_q[AR_V];
      word.n = ar_q[AR_N];
      word.z = ar_q[AR_Z];
      word.c = ar_q[AR_C];
      word.s = ar_q[AR_N] ^ ar_q[AR_V];
   end

   // R4
   alu_carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_mask[AR_C] |=> (word.c == $past(alu_flags[AR_C])));

   // R4
   alu_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_mask[AR_Z] && !io_we) |=> $stable(word.z));

   // R7
   accept_clears_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_accept |=> !word.i);

   // R7
   return_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && !irq_accept) |=> word.i);
endmodule

// File: rtl/psw_status_reg.sv
module psw_status_reg
   import psw_pkg::*;
#(
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned IO_ADDR = 'h3F,
   parameter int unsigned NUM_IRQ = 4,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic               io_wr,
   input  logic [7:0]         io_wdata,
   output logic [7:0]         io_rdata,
   input  logic [4:0]         alu_mask,
   input  logic [4:0]         alu_flags,
   input  logic [2:0]         bit_idx,
   input  logic [7:0]         bit_opnd,
   input  logic               bit_store,
   output logic [7:0]         bit_load_data,
   input  logic               irq_accept,
   input  logic               irq_return,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic [NUM_IRQ-1:0] irq_fwd,
   output logic [7:0]         status
);
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(IO_ADDR);

   generate
      if (IO_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("psw_status_reg: IO_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   logic io_hit, io_we, t_sel;
   psw_t word;

   assign io_hit = (io_addr == SEL_ADDR);
   assign io_we  = io_wr && io_hit;

   psw_flag_store u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_we      (io_we),
      .io_word    (psw_t'(io_wdata)),
      .alu_mask   (alu_mask),
      .alu_flags  (alu_flags),
      .t_we       (bit_store),
      .t_val      (t_sel),
      .irq_accept (irq_accept),
      .irq_return (irq_return),
      .word       (word)
   );

   psw_bit_xfer #(.DATA_W(PSW_W)) u_xfer (
      .opnd      (bit_opnd),
      .idx       (bit_idx),
      .t_in      (word.t),
      .sel_bit   (t_sel),
      .load_data (bit_load_data)
   );

   psw_irq_gate #(.NUM_IRQ(NUM_IRQ), .REG_OUT(IRQ_REG)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .gie   (word.i),
      .req   (irq_req),
      .en    (irq_en),
      .fwd   (irq_fwd)
   );

   assign status   = word;
   assign io_rdata = io_hit ? word : '0;

   // R8
   store_to_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_store |=> (status[6] == $past(bit_opnd[bit_idx])));

   // R2
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_hit && alu_mask == '0 && !bit_store && !irq_accept && !irq_return)
      |=> $stable(status));
endmodule

// File: tb/psw_status_reg_bench.sv
`timescale 1ns/1ps
module psw_status_reg_bench;
   logic       clk = 0;
   logic       rst_n = 0;
   logic [5:0] io_addr = 0;
   logic       io_wr = 0;
   logic [7:0] io_wdata = 0;
   logic [7:0] io_rdata;
   logic [4:0] alu_mask = 0, alu_flags = 0;
   logic [2:0] bit_idx = 0;
   logic [7:0] bit_opnd = 0;
   logic       bit_store = 0;
   logic [7:0] bit_load_data;
   logic       irq_accept = 0, irq_return = 0;
   logic [3:0] irq_req = 0, irq_en = 0, irq_fwd;
   logic [7:0] status;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   logic [7:0] exp_w;

   always #2.5 clk = ~clk;

   psw_status_reg u_psw_status_reg (.*);

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] fix_s(logic [7:0] w);
      fix_s = w;
      fix_s[4] = w[3] ^ w[2];
   endfunction

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic io_write(logic [7:0] d);
      io_addr = 6'h3F; io_wr = 1; io_wdata = d;
      tick();
      io_wr = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] a, b, t;
      #12 rst_n = 1;
      tick();
      // R1: reset state
      io_addr = 6'h3F; #1;
      chk("R1 status", status, 8'h00);
      chk("R1 rdata", io_rdata, 8'h00);
      irq_req = 4'hF; irq_en = 4'hF; #1;
      chk("R1 fwd", {4'h0, irq_fwd}, 8'h00);
      irq_req = 0; irq_en = 0;

      // R2/R3: every byte over I/O
      for (int v = 0; v < 256; v++) begin
         io_write(8'(v));
         chk("R2/R3 io write", io_rdata, fix_s(8'(v)));
      end
      exp_w = fix_s(8'hFF);
      // R2: foreign address ignored and reads 0
      io_write(8'h00);
      exp_w = 8'h00;
      io_addr = 6'h3E; io_wr = 1; io_wdata = 8'hFF;
      tick(); io_wr = 0;
      chk("R2 foreign rdata", io_rdata, 8'h00);
      chk("R2 foreign status", status, exp_w);

      // R4/R3: random masked ALU updates
      io_write(8'h5A); exp_w = fix_s(8'h5A);
      for (int n = 0; n < 300; n++) begin
         alu_mask = 5'($urandom); alu_flags = 5'($urandom);
         if (alu_mask[4]) exp_w[5] = alu_flags[4];
         for (int k = 0; k < 4; k++)
            if (alu_mask[k]) exp_w[k] = alu_flags[k];
         exp_w = fix_s(exp_w);
         tick();
         alu_mask = 0;
         chk("R4/R3 alu", status, exp_w);
      end

      // R5: ALU beats I/O write on masked flags
      io_addr = 6'h3F; io_wr = 1; io_wdata = 8'h00;
      alu_mask = 5'b00001; alu_flags = 5'b11111;
      tick(); io_wr = 0; alu_mask = 0;
      chk("R5 collision", status, 8'h01);
      io_wr = 1; io_wdata = 8'hEF; alu_mask = 5'b10100; alu_flags = 5'b00000;
      tick(); io_wr = 0; alu_mask = 0;
      chk("R5 collision2", status, fix_s(8'hCB));

      // R6: gating sweep
      for (int g = 0; g < 2; g++) begin
         io_write(g ? 8'h80 : 8'h00);
         for (int r = 0; r < 16; r++)
            for (int e = 0; e < 16; e++) begin
               irq_req = 4'(r); irq_en = 4'(e); #1;
               chk("R6 gate", {4'h0, irq_fwd}, g ? 8'(r & e) : 8'h00);
            end
      end
      irq_req = 0; irq_en = 0;

      // R7/R10
      io_write(8'hED); exp_w = fix_s(8'hED);
      irq_accept = 1; tick(); irq_accept = 0;
      chk("R7/R10 accept", status, exp_w & 8'h7F);
      irq_return = 1; tick(); irq_return = 0;
      chk("R7/R10 return", status, exp_w);
      io_wr = 1; io_wdata = 8'hED; irq_accept = 1; irq_return = 1;
      tick(); io_wr = 0; irq_accept = 0; irq_return = 0;
      chk("R7 accept wins", status[7] ? 8'h1 : 8'h0, 8'h0);
      io_wr = 1; io_wdata = 8'h00; irq_return = 1;
      tick(); io_wr = 0; irq_return = 0;
      chk("R7 return beats io", status, 8'h80);

      // R8/R9: store/load round trip on every index
      for (int i = 0; i < 8; i++)
         for (int p = 0; p < 4; p++) begin
            a = 8'($urandom); b = 8'($urandom);
            if (p == 0) a[i] = 1'b0;
            if (p == 1) a[i] = 1'b1;
            bit_idx = 3'(i); bit_opnd = a; bit_store = 1;
            tick(); bit_store = 0;
            chk("R8 store", {7'h0, status[6]}, {7'h0, a[i]});
            bit_opnd = b; #1;
            t = b; t[i] = a[i];
            chk("R9 load", bit_load_data, t);
         end

      // R8: bit-store beats I/O write on T
      bit_idx = 3'd2; bit_opnd = 8'h04; bit_store = 1;
      io_wr = 1; io_wdata = 8'h00;
      tick(); bit_store = 0; io_wr = 0;
      chk("R8 store beats io", status, 8'h40);

      finish_run();
   end
endmodule